// File: doc/BRIEF.md
# Packet Command Queue Interface

This block is a small register set through which a host assembles a five-word packet command and passes it to a downstream packet engine. The host uses a plain 32-bit register bus with a byte address, a write strobe, a read strobe and combinational read data. Four of the five command words are only staged when written. Writing the packet-length word places the whole command on a valid/ready output toward the engine.

The engine returns an 8-bit completion status on a one-cycle result strobe. The block stores this status inside the control/status word, where the host can read it back. It also sorts the status into one of three classes: success, failure or notification.

An input pin can reverse the byte order of host write data before the block stores it. If the host writes the length word while the engine still holds an unaccepted command, the write is dropped and a sticky overflow flag is raised.

Top module: `pkt_cmd_queue`

## Requirements
- R1: After reset, a read of the control/status word (offset 0x00) returns 0x00000002. The flag word (offset 0x14) and the words at 0x04, 0x08, 0x0C and 0x10 read 0. `cmd_valid` is low.
- R2: Writes to offsets 0x00, 0x04, 0x08 and 0x0C only stage data and never raise `cmd_valid`. A write to offset 0x10, made when no command is waiting, raises `cmd_valid` on the following clock edge.
- R3: Bits [23:16] of a host write to offset 0x00 are ignored. In a read of offset 0x00, those bits carry the most recent result status, which is 0 before any result arrives. Bits [23:16] of `cmd_cs` are 0.
- R4: When `res_valid` is high, the block latches `res_status` as the status byte and sets the done flag (flag word bit 0).
- R5: Each result is classified as follows. Status 0x00 is success, with the fail and notify flags both clear. A non-zero bits [3:0] is a failure and sets the fail flag (flag word bit 1). Zero bits [3:0] with non-zero bits [7:4] is a notification and sets the notify flag (flag word bit 2), not the fail flag.
- R6: A host read of offset 0x00 clears the done, fail and notify flags. The stored status byte is not cleared. A result arriving in the same cycle as the read takes priority.
- R7: A write to offset 0x10 while `cmd_valid` is high and `cmd_ready` is low is dropped. It sets the sticky overflow flag (flag word bit 3) and leaves the staged word at 0x10 and the command output unchanged. A read of offset 0x14 clears the overflow flag.
- R8: While `cmd_valid` is high and `cmd_ready` is low, all five command words hold stable. This is true even if the staged words are rewritten. Each launched command equals the five words the host wrote, in order 0x00, 0x04, 0x08, 0x0C, 0x10. `cmd_valid` falls after a cycle in which `cmd_ready` is high, unless a new launch happens in that cycle.
- R9: When `host_swap` is high, the write data is byte-reversed before it is stored or launched: byte 0 and byte 3 exchange places, and byte 1 and byte 2 exchange places.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Byte address of the register access |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe; triggers clear-on-read side effects |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, combinational from the address |
| host_swap | input | 1 | Byte-reverse host write data |
| cmd_valid | output | 1 | A command is waiting for the engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_cs | output | 32 | Command control/status word |
| cmd_src | output | 32 | Command source address |
| cmd_dst | output | 32 | Command destination address |
| cmd_sa | output | 32 | Command security-association handle |
| cmd_len | output | 32 | Command control and packet length word |
| res_valid | input | 1 | Engine result strobe |
| res_status | input | 8 | Engine result status byte |

## Verification
Several properties are checked by assertions on every cycle. A launch only ever follows a length-word write. A waiting command holds still until the engine is ready. A dropped launch always leaves the overflow flag set. A result always sets done and stores its status. The fail and notify flags always agree with the nibbles of the stored status.

Other behaviour can only be shown by the bench scenarios. These cover the reset values seen through reads, and whether the launched words match what the host wrote. They also cover the masking of the status field on writes, the flags clearing on the proper reads, and the byte reversal.

// File: rtl/pkt_cmd_queue.sv
module pkt_cmd_queue #(
  parameter int ADDR_W = 5,
  parameter logic [31:0] CS_RESET = 32'h0000_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              host_swap,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [31:0]       cmd_cs,
  output logic [31:0]       cmd_src,
  output logic [31:0]       cmd_dst,
  output logic [31:0]       cmd_sa,
  output logic [31:0]       cmd_len,
  input  logic              res_valid,
  input  logic [7:0]        res_status
);
  localparam logic [ADDR_W-1:0] OFF_CS  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFF_SRC = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFF_DST = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFF_SA  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFF_LEN = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFF_FLG = ADDR_W'('h14);

  logic [31:0] wd, cs_q, src_q, dst_q, sa_q, len_q;
  logic [7:0]  stat_q;
  logic        done_q, fail_q, note_q, ovf_q;

  assign wd = host_swap ? {host_wdata[7:0], host_wdata[15:8], host_wdata[23:16], host_wdata[31:24]}
                        : host_wdata;

  wire wr_cs  = host_wr && host_addr == OFF_CS;
  wire wr_src = host_wr && host_addr == OFF_SRC;
  wire wr_dst = host_wr && host_addr == OFF_DST;
  wire wr_sa  = host_wr && host_addr == OFF_SA;
  wire wr_len = host_wr && host_addr == OFF_LEN;
  wire rd_cs  = host_rd && host_addr == OFF_CS;
  wire rd_flg = host_rd && host_addr == OFF_FLG;
  wire busy   = cmd_valid && !cmd_ready;
  wire launch = wr_len && !busy;
  wire drop   = wr_len && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q  <= CS_RESET;
      src_q <= '0;
      dst_q <= '0;
      sa_q  <= '0;
      len_q <= '0;
    end else begin
      if (wr_cs)  cs_q  <= {wd[31:24], 8'h00, wd[15:0]};
      if (wr_src) src_q <= wd;
      if (wr_dst) dst_q <= wd;
      if (wr_sa)  sa_q  <= wd;
      if (launch) len_q <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_cs    <= '0;
      cmd_src   <= '0;
      cmd_dst   <= '0;
      cmd_sa    <= '0;
      cmd_len   <= '0;
    end else if (launch) begin
      cmd_valid <= 1'b1;
      cmd_cs    <= cs_q;
      cmd_src   <= src_q;
      cmd_dst   <= dst_q;
      cmd_sa    <= sa_q;
      cmd_len   <= wd;
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      note_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (res_valid) begin
        stat_q <= res_status;
        done_q <= 1'b1;
        fail_q <= |res_status[3:0];
        note_q <= (res_status[3:0] == 4'h0) && (|res_status[7:4]);
      end else if (rd_cs) begin
        done_q <= 1'b0;
        fail_q <= 1'b0;
        note_q <= 1'b0;
      end
      if (drop)        ovf_q <= 1'b1;
      else if (rd_flg) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    case (host_addr)
      OFF_CS:  host_rdata = {cs_q[31:24], stat_q, cs_q[15:0]};
      OFF_SRC: host_rdata = src_q;
      OFF_DST: host_rdata = dst_q;
      OFF_SA:  host_rdata = sa_q;
      OFF_LEN: host_rdata = len_q;
      OFF_FLG: host_rdata = {28'h0, ovf_q, note_q, fail_q, done_q};
      default: host_rdata = '0;
    endcase
  end

  p_launch_only_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(wr_len));

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable({cmd_cs, cmd_src, cmd_dst, cmd_sa, cmd_len}));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_q && $stable(len_q));

  p_result_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> done_q && stat_q == $past(res_status));

  p_fail_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> stat_q[3:0] != 4'h0);

  p_note_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
    note_q |-> stat_q[3:0] == 4'h0 && stat_q[7:4] != 4'h0);

  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cs && !res_valid |=> !done_q && !fail_q && !note_q);

  p_cs_field_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_cs[23:16] == 8'h00);
endmodule

// File: tb/pkt_cmd_queue_tb.sv
module pkt_cmd_queue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0, host_swap = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [31:0] cmd_cs, cmd_src, cmd_dst, cmd_sa, cmd_len;
  logic        res_valid = 1'b0;
  logic [7:0]  res_status = '0;
  int          n_run = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  pkt_cmd_queue u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_swap(host_swap),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_cs(cmd_cs), .cmd_src(cmd_src),
    .cmd_dst(cmd_dst), .cmd_sa(cmd_sa), .cmd_len(cmd_len),
    .res_valid(res_valid), .res_status(res_status));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic result(input logic [7:0] s);
    @(negedge clk);
    res_status = s; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 cmd_valid", {31'h0, cmd_valid}, 32'h0);
    rd(5'h00, d); check("R1 cs reset", d, 32'h0000_0002);
    rd(5'h14, d); check("R1 flags reset", d, 32'h0);
    rd(5'h10, d); check("R1 len reset", d, 32'h0);
  endtask

  task automatic t_launch();
    logic [31:0] d;
    wr(5'h00, 32'hA5FF_3C11);
    wr(5'h04, 32'h1000_0040);
    wr(5'h08, 32'h2000_0080);
    wr(5'h0C, 32'h0000_BEEF);
    check("R2 no launch on staging", {31'h0, cmd_valid}, 32'h0);
    rd(5'h00, d); check("R3 status field ignored", d, 32'hA500_3C11);
    wr(5'h10, 32'h0001_05DC);
    check("R2 launch", {31'h0, cmd_valid}, 32'h1);
    check("R8 cs", cmd_cs, 32'hA500_3C11);
    check("R8 src", cmd_src, 32'h1000_0040);
    check("R8 dst", cmd_dst, 32'h2000_0080);
    check("R8 sa", cmd_sa, 32'h0000_BEEF);
    check("R8 len", cmd_len, 32'h0001_05DC);
    wr(5'h04, 32'h3333_3333);
    repeat (3) @(negedge clk);
    check("R8 hold valid", {31'h0, cmd_valid}, 32'h1);
    check("R8 src stable", cmd_src, 32'h1000_0040);
    wr(5'h10, 32'h0000_0077);
    check("R7 len output unchanged", cmd_len, 32'h0001_05DC);
    rd(5'h10, d); check("R7 staged len unchanged", d, 32'h0001_05DC);
    rd(5'h14, d); check("R7 overflow set", d & 32'h8, 32'h8);
    rd(5'h14, d); check("R7 overflow cleared", d & 32'h8, 32'h0);
    @(negedge clk); cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
    check("R8 valid drops", {31'h0, cmd_valid}, 32'h0);
    wr(5'h10, 32'h0000_0100);
    check("R8 second src", cmd_src, 32'h3333_3333);
    @(negedge clk); cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
  endtask

  task automatic t_result();
    logic [31:0] d;
    result(8'h00);
    rd(5'h14, d); check("R4 R5 success flags", d, 32'h1);
    rd(5'h00, d); check("R3 status readback 00", d[23:16], 32'h00);
    rd(5'h14, d); check("R6 flags cleared", d, 32'h0);
    result(8'h35);
    rd(5'h14, d); check("R5 fail flags", d, 32'h3);
    rd(5'h00, d); check("R4 status 35", d, 32'hA535_3C11);
    result(8'h40);
    rd(5'h14, d); check("R5 notify flags", d, 32'h5);
    rd(5'h00, d);
    rd(5'h00, d); check("R6 status kept", d[23:16], 32'h40);
    rd(5'h14, d); check("R6 notify cleared", d, 32'h0);
  endtask

  task automatic t_swap();
    logic [31:0] d;
    host_swap = 1'b1;
    wr(5'h04, 32'hDEAD_BEEF);
    wr(5'h10, 32'h1122_3344);
    host_swap = 1'b0;
    check("R9 launched swapped", cmd_len, 32'h4433_2211);
    check("R9 src swapped", cmd_src, 32'hEFBE_ADDE);
    rd(5'h04, d); check("R9 staged swapped", d, 32'hEFBE_ADDE);
    @(negedge clk); cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_launch();
    t_result();
    t_swap();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule